// File: doc/BRIEF.md
# SPI Mode-0 Master with Looped-Back Clock Capture

This block is an SPI master that works only in mode 0. It has two halves. The transmit half takes bytes from a valid/ready stream and drives SCLK and MOSI. It runs on a tick divider, and each data bit takes two ticks. The receive half is built like a slave. It does not sample MISO on the master's own internal edges. Instead it watches a feedback clock input: the outgoing SCLK, wired back from the far end of the link. It samples MISO when that returned clock is high.

The returned clock and MISO pass through matching input paths, so the pad and cable round trip cancels out. The bit rate is then limited by the system clock rather than by I/O delay. A configuration input selects a fast receive mode for SCLK at half the system clock. In that mode the receiver re-arms at once and does not wait for the returned clock to go low. Received bytes leave on a valid-only stream.

Top module: `spi_loopcap_master`

## Requirements
- R1: Only mode 0 is supported. While `cpol_i` or `cpha_i` is 1, `tx_ready_o` stays 0, no byte is accepted and SCLK does not rise.
- R2: MOSI changes only on the tick that drives SCLK low. SCLK rises on the next tick, and MOSI does not change at that moment.
- R3: A tick occurs every `div_i` clock cycles, with 0 treated as 1. A bit takes two ticks, so inside a byte SCLK rises every 2·`div_i` cycles. With `div_i`=1, SCLK runs at half the clock.
- R4: A byte is taken when `tx_valid_i` and `tx_ready_o` are both 1 at a clock edge. `tx_ready_o` is 1 when no byte is in flight and the mode is valid. The 8 bits go out least-significant bit first, and the next byte is fetched once all 8 have been sent.
- R5: When no byte is pending, SCLK rests low and MOSI keeps the last bit sent (bit 7 of the last byte).
- R6: The receiver samples MISO, once per bit, when the synchronized feedback clock is high. MISO passes through the same number of flops as the feedback clock. With `fast_i`=0, the receiver waits for the feedback clock to go low before it arms for the next bit.
- R7: With `fast_i`=1, the receiver skips the wait for the low phase. This mode is valid for `div_i`=1.
- R8: Received bits fill the byte from bit 0 upward. After every 8th sample, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one cycle.
- R9: With MOSI looped to MISO and SCLK looped to the feedback input through equal delays, every byte sent comes back unchanged and in order. This holds with `fast_i`=1 at `div_i`=1 and with `fast_i`=0 at `div_i`≥2.
- R10: After reset, SCLK is 0, MOSI is 0, `rx_valid_o` is 0, and `tx_ready_o` is 1 when the mode is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Clock cycles per transmit tick (0 acts as 1) |
| cpol_i | input | 1 | Clock polarity request; must be 0 |
| cpha_i | input | 1 | Clock phase request; must be 0 |
| fast_i | input | 1 | Receiver skips wait-for-low |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| sclk_o | output | 1 | SPI clock out |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sclk_fb_i | input | 1 | SCLK returned from the far end |

## Verification
The assertions check the mode-0 data/clock relationship on every cycle: MOSI moves only while SCLK goes low, and SCLK rises with MOSI still. They also check that SCLK moves only on divider ticks and that the receive strobe never lasts more than one cycle. Other behaviours need the bench's scenarios. These are the LSB-first bit order on the wire, the SCLK period for a chosen divider, rejection of a non-zero polarity or phase, the idle level between bytes, and the return of every byte through a delayed loopback in both receive modes.

// File: rtl/spi_lc_pkg.sv
package spi_lc_pkg;
  typedef enum logic {
    RX_ARM_HI = 1'b0,
    RX_ARM_LO = 1'b1
  } rx_state_e;
endpackage

// File: rtl/spi_lc_tick.sv
module spi_lc_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o = (cnt_q >= lim - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_lc_tx.sv
module spi_lc_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_ok_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int BW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic              busy_q;
  logic              hi_phase_q;

  assign ready_o = mode_ok_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_q      <= '0;
      busy_q     <= 1'b0;
      hi_phase_q <= 1'b0;
      sclk_o     <= 1'b0;
      mosi_o     <= 1'b0;
    end else begin
      if (valid_i && ready_o) begin
        sh_q       <= data_i;
        bit_q      <= '0;
        busy_q     <= 1'b1;
        hi_phase_q <= 1'b0;
      end
      if (tick_i) begin
        if (!busy_q) begin
          sclk_o <= 1'b0;
        end else if (!hi_phase_q) begin
          // low half: present next bit
          mosi_o     <= sh_q[0];
          sh_q       <= sh_q >> 1;
          sclk_o     <= 1'b0;
          hi_phase_q <= 1'b1;
        end else begin
          sclk_o     <= 1'b1;
          hi_phase_q <= 1'b0;
          bit_q      <= bit_q + BW'(1);
          if (bit_q == BW'(DATA_W - 1)) busy_q <= 1'b0;
        end
      end
    end
  end

  assert_mosi_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sclk_o);
  assert_rise_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  assert_sclk_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sclk_o));
endmodule

// File: rtl/spi_lc_sync.sv
module spi_lc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) st_q[0] <= 1'b0;
          else         st_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) st_q[i] <= 1'b0;
          else         st_q[i] <= st_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_lc_rx.sv
module spi_lc_rx
  import spi_lc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic              sclk_s_i,
  input  logic              miso_s_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int BW = $clog2(DATA_W);

  rx_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_nx;

  assign sh_nx = {miso_s_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_ARM_HI;
      sh_q    <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (st_q == RX_ARM_HI && sclk_s_i) begin
        sh_q  <= sh_nx;
        cnt_q <= cnt_q + BW'(1);
        if (cnt_q == BW'(DATA_W - 1)) begin
          data_o  <= sh_nx;
          valid_o <= 1'b1;
          cnt_q   <= '0;
        end
        st_q <= fast_i ? RX_ARM_HI : RX_ARM_LO;
      end else if (st_q == RX_ARM_LO && !sclk_s_i) begin
        st_q <= RX_ARM_HI;
      end
    end
  end

  assert_rx_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/spi_loopcap_master.sv
module spi_loopcap_master #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              fast_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sclk_fb_i
);
  logic tick;
  logic mode_ok;
  logic sclk_s;
  logic miso_s;

  assign mode_ok = !cpol_i && !cpha_i;

  spi_lc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  spi_lc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .mode_ok_i(mode_ok),
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  // equal depth keeps data aligned with the returned clock
  spi_lc_sync #(.STAGES(SYNC_N)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_fb_i), .q_o(sclk_s)
  );
  spi_lc_sync #(.STAGES(SYNC_N)) u_sync_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(miso_i), .q_o(miso_s)
  );

  spi_lc_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fast_i(fast_i), .sclk_s_i(sclk_s),
    .miso_s_i(miso_s), .data_o(rx_data_o), .valid_o(rx_valid_o)
  );
endmodule

// File: tb/spi_loopcap_master_test.sv
`timescale 1ns/1ps
module spi_loopcap_master_test;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd2;
  logic       cpol = 1'b0, cpha = 1'b0, fast = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, rx_valid, sclk, mosi;
  logic [7:0] rx_data;
  logic [LAT-1:0] sclk_d = '0, mosi_d = '0;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic bitq[$];
  logic [7:0] byteq[$];
  int rises = 0, last_rise = 0, bit_in_byte = 0, cur_div = 2;
  logic prev_sclk = 1'b0;

  always #2.5 clk = ~clk;

  spi_loopcap_master uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cpol_i(cpol), .cpha_i(cpha),
    .fast_i(fast), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(mosi_d[LAT-1]),
    .sclk_fb_i(sclk_d[LAT-1])
  );

  // loopback with equal delay on clock and data
  always @(posedge clk) begin
    sclk_d <= {sclk_d[LAT-2:0], sclk};
    mosi_d <= {mosi_d[LAT-2:0], mosi};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: bit-level and byte-level scoreboards
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        rises++;
        if (bit_in_byte != 0)
          check(cyc - last_rise == 2 * cur_div, "R3 sclk period", cyc - last_rise, 2 * cur_div);
        last_rise = cyc;
        bit_in_byte = (bit_in_byte + 1) % 8;
        if (bitq.size() > 0) begin
          logic b;
          b = bitq.pop_front();
          check(mosi == b, "R4 mosi bit order", mosi, b);
        end else check(1'b0, "R4 unexpected sclk rise", 1, 0);
      end
      if (rx_valid) begin
        if (byteq.size() > 0) begin
          logic [7:0] e;
          e = byteq.pop_front();
          check(rx_data == e, "R9 R8 loopback byte", rx_data, e);
        end else check(1'b0, "R8 unexpected rx strobe", rx_data, 0);
      end
    end
    prev_sclk = sclk;
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    for (int i = 0; i < 8; i++) bitq.push_back(d[i]);
    byteq.push_back(d);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && byteq.size() > 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(byteq.size() == 0, "R9 all bytes returned", byteq.size(), 0);
  endtask

  task automatic set_cfg(input int d, input logic f);
    @(negedge clk);
    div = 8'(d);
    cur_div = (d == 0) ? 1 : d;
    fast = f;
    bit_in_byte = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0, "R10 sclk reset", sclk, 0);
    check(mosi == 1'b0, "R10 mosi reset", mosi, 0);
    check(rx_valid == 1'b0, "R10 rx_valid reset", rx_valid, 0);
    check(tx_ready == 1'b1, "R10 tx_ready reset", tx_ready, 1);

    // R6: normal receive mode, several dividers
    set_cfg(2, 1'b0);
    send(8'hA5); send(8'h3C); send(8'h01);
    drain();
    set_cfg(3, 1'b0);
    send(8'h80); send(8'hFF); send(8'h00);
    drain();
    set_cfg(8, 1'b0);
    send(8'h5A); send(8'hC3);
    drain();

    // R5: idle levels after last byte (0xC3 bit 7 = 1)
    repeat (40) @(negedge clk);
    check(sclk == 1'b0, "R5 idle sclk low", sclk, 0);
    check(mosi == 1'b1, "R5 mosi holds last bit", mosi, 1);

    // R7: fast receive mode at half the clock
    set_cfg(1, 1'b1);
    send(8'h12); send(8'h34); send(8'hED); send(8'h7E);
    drain();
    set_cfg(0, 1'b1); // R3: zero acts as one
    send(8'h96); send(8'h69);
    drain();

    // R1: non-zero polarity or phase is refused
    begin
      int r0;
      bit any_ready;
      r0 = rises;
      any_ready = 1'b0;
      @(negedge clk);
      cpol = 1'b1;
      tx_data = 8'hAA;
      tx_valid = 1'b1;
      repeat (40) begin @(negedge clk); if (tx_ready) any_ready = 1'b1; end
      cpol = 1'b0; cpha = 1'b1;
      repeat (40) begin @(negedge clk); if (tx_ready) any_ready = 1'b1; end
      tx_valid = 1'b0;
      cpha = 1'b0;
      check(!any_ready, "R1 ready held low", any_ready, 0);
      check(rises == r0, "R1 no sclk activity", rises - r0, 0);
      check(sclk == 1'b0, "R1 sclk idle", sclk, 0);
    end
    repeat (20) @(negedge clk);
    check(byteq.size() == 0, "R1 nothing received", byteq.size(), 0);

    // R4: back-to-back bytes after mode restored
    set_cfg(2, 1'b0);
    send(8'hF0); send(8'h0F);
    drain();
    check(bitq.size() == 0, "R4 all bits on wire", bitq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule